// File: doc/BRIEF.md
# Bytewide SRAM Pin Front End

This block sits behind the pins of a classic asynchronous bytewide static RAM port and runs on a fast internal clock. It samples chip enable, output enable, write enable, the address and the incoming data. From those samples it decides whether the port is reading, writing or deselected. It drives a local byte array and returns the read byte together with an enable for the tri-state data pads.

The three control pins each pass through a two-flop synchronizer. Address and data go through two flops as well, so that all samples stay aligned.

A write window opens when both chip enable and write enable are sampled low. It closes when either of them returns high. The byte and address sampled last while the window was open are then committed.

A protect input from a power supervisor overrides everything. While it is high the pads are released and the pins are ignored. A write that is open when protect rises is dropped.

The array depth is `2**ADDR_W` bytes. A 15-bit address gives 32K x 8, and the default is kept smaller.

Top module: `sram_bus_front`

## Requirements
- R1: The array holds `2**ADDR_W` bytes of 8 bits each. Every address from 0 up to `2**ADDR_W-1` stores its own independent byte.
- R2: Each pin change reaches `dat_oe` and `dat_out` on the third rising clock edge after the pin is sampled.
  - The result is not visible on the second edge.
  - The `prot` input acts on the next rising edge.
- R3: `dat_oe` is high exactly when all four of these hold for the sampled pins:
  - chip enable is low;
  - output enable is low;
  - write enable is high;
  - `prot` is low.
  While `dat_oe` is high, `dat_out` carries the byte stored at the sampled address.
- R4: If the address changes while a read stays active, `dat_out` follows the new location with the R2 latency.
- R5: A write window opens when the later of chip enable and write enable falls, so that both are low. It closes when the earlier of the two rises. The byte is committed when the window closes.
  - Windows controlled by chip enable are supported.
  - Windows controlled by write enable are supported.
- R6: A commit uses the address and data sampled in the last cycle before the window closed. Earlier data values driven inside the window are discarded.
- R7: A low write enable forces `dat_oe` low, even when chip enable and output enable are both low.
- R8: If chip enable and write enable fall in the same sample while output enable is low, `dat_oe` stays low for the whole window.
- R9: A read can begin in the same cycle that a rising write enable closes a window on the same address. That read returns the byte just written.
- R10: While `prot` is high, three things hold:
  - `dat_oe` is low;
  - no commit takes place;
  - an open window is dropped.
  After `prot` falls, a new window needs a fresh falling edge of chip enable or write enable.
- R11: After reset, `dat_oe` and `dat_out` are zero and no write window is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_ce_n | input | 1 | Chip enable pin, active low |
| pin_oe_n | input | 1 | Output enable pin, active low |
| pin_we_n | input | 1 | Write enable pin, active low |
| pin_addr | input | ADDR_W | Address pins |
| pin_din | input | 8 | Data pins, inbound value |
| prot | input | 1 | Supervisor protect, high forces deselect |
| dat_out | output | 8 | Read byte toward the data pads |
| dat_oe | output | 1 | Pad drive enable for the data bus |

## Verification
A commit and a read of the same address can land in the same cycle. This happens when write enable rises while chip enable and output enable stay low. The bench provokes it right after write enable has pulled the outputs off a live read. It expects the pads to drive again three cycles later with the freshly written byte rather than the old one.

A second collision is protect rising while a window is open. The bench judges it by reading the location back afterwards and expecting its earlier content.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'd0,
        MD_READ  = 2'd1,
        MD_WRITE = 2'd2,
        MD_GUARD = 2'd3
    } sbf_mode_e;

endpackage

// File: rtl/sbf_sync.sv
module sbf_sync #(
    parameter int          W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= {W{RST_VAL}};
            st_q.s2 <= {W{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign d_out = st_q.s2;
endmodule

// File: rtl/sbf_decode.sv
module sbf_decode
    import sbf_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_ce_n,
    input  logic              s_oe_n,
    input  logic              s_we_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_dat,
    input  logic              prot,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_dat,
    output logic              drive_d,
    output logic              win_open,
    output sbf_mode_e         mode
);
    typedef struct packed {
        logic              both_low;
        logic              open;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdat;
    } dec_t;

    dec_t      st_d, st_q;
    logic      both_low;
    sbf_mode_e mode_c;

    always_comb begin
        both_low      = !s_ce_n && !s_we_n;
        st_d          = st_q;
        st_d.both_low = both_low;
        wr_en         = 1'b0;
        mode_c        = MD_IDLE;

        if (prot) begin
            st_d.open = 1'b0;
            mode_c    = MD_GUARD;
        end else if (both_low) begin
            if (st_q.open || !st_q.both_low) begin
                st_d.open  = 1'b1;
                st_d.waddr = s_addr;
                st_d.wdat  = s_dat;
                mode_c     = MD_WRITE;
            end
        end else begin
            if (st_q.open) begin
                wr_en     = 1'b1;
                st_d.open = 1'b0;
            end
            if (!s_ce_n && s_we_n) begin
                mode_c = MD_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr  = st_q.waddr;
    assign wr_dat   = st_q.wdat;
    assign drive_d  = (mode_c == MD_READ) && !s_oe_n;
    assign win_open = st_q.open;
    assign mode     = mode_c;
endmodule

// File: rtl/sbf_array.sv
module sbf_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_dat,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              drive_d,
    output logic [DATA_W-1:0] dat_out,
    output logic              dat_oe
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              oe;
    } out_t;

    logic [DATA_W-1:0] mem [DEPTH];
    out_t              st_d, st_q;
    logic              hit;

    always_comb begin
        hit     = wr_en && (wr_addr == rd_addr);
        st_d.oe = drive_d;
        st_d.dout = hit ? wr_dat : mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_dat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dat_out = st_q.dout;
    assign dat_oe  = st_q.oe;
endmodule

// File: rtl/sram_bus_front.sv
module sram_bus_front
    import sbf_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_ce_n,
    input  logic              pin_oe_n,
    input  logic              pin_we_n,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic [7:0]        pin_din,
    input  logic              prot,
    output logic [7:0]        dat_out,
    output logic              dat_oe
);
    localparam int DATA_W = 8;
    localparam int CTRL_W = 3;
    localparam int BUS_W  = ADDR_W + DATA_W;

    logic [CTRL_W-1:0] s_ctrl;
    logic [BUS_W-1:0]  s_bus;
    logic              s_ce_n, s_oe_n, s_we_n;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_dat;
    logic              wr_en, drive_d, win_open;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_dat;
    sbf_mode_e         mode;

    sbf_sync #(.W(CTRL_W), .RST_VAL(1'b1)) i_sync_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({pin_ce_n, pin_oe_n, pin_we_n}),
        .d_out (s_ctrl)
    );

    sbf_sync #(.W(BUS_W), .RST_VAL(1'b0)) i_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({pin_addr, pin_din}),
        .d_out (s_bus)
    );

    assign {s_ce_n, s_oe_n, s_we_n} = s_ctrl;
    assign {s_addr, s_dat}          = s_bus;

    sbf_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_ce_n   (s_ce_n),
        .s_oe_n   (s_oe_n),
        .s_we_n   (s_we_n),
        .s_addr   (s_addr),
        .s_dat    (s_dat),
        .prot     (prot),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_dat   (wr_dat),
        .drive_d  (drive_d),
        .win_open (win_open),
        .mode     (mode)
    );

    sbf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_dat  (wr_dat),
        .rd_addr (s_addr),
        .drive_d (drive_d),
        .dat_out (dat_out),
        .dat_oe  (dat_oe)
    );
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker (
    input logic clk,
    input logic rst_n,
    input logic prot,
    input logic s_ce_n,
    input logic s_oe_n,
    input logic s_we_n,
    input logic wr_en,
    input logic win_open,
    input logic dat_oe
);
    p_prot_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prot |=> !dat_oe);

    p_prot_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !prot);

    p_we_kills_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_we_n |=> !dat_oe);

    p_drive_needs_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe) |-> $past(!s_ce_n && !s_oe_n && s_we_n && !prot));

    p_commit_after_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> win_open);

    p_commit_on_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (s_ce_n || s_we_n));
endmodule

bind sram_bus_front sbf_checker i_sbf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .prot     (prot),
    .s_ce_n   (s_ce_n),
    .s_oe_n   (s_oe_n),
    .s_we_n   (s_we_n),
    .wr_en    (wr_en),
    .win_open (win_open),
    .dat_oe   (dat_oe)
);

// File: tb/test_sram_bus_front.sv
module test_sram_bus_front;
    localparam int AW = 11;

    typedef struct {
        int         cyc;
        bit         oe;
        logic [7:0] d;
        string      req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, prot = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dat_out;
    logic          dat_oe;

    int   cnt = 0;
    int   checks = 0;
    int   failures = 0;
    exp_t sbq[$];
    logic [7:0] ref_mem [int];

    always #2.5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    sram_bus_front #(.ADDR_W(AW)) i_sram_bus_front (
        .clk(clk), .rst_n(rst_n), .pin_ce_n(ce_n), .pin_oe_n(oe_n),
        .pin_we_n(we_n), .pin_addr(addr), .pin_din(din), .prot(prot),
        .dat_out(dat_out), .dat_oe(dat_oe)
    );

    // monitor: compares due scoreboard items at every falling edge
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].cyc <= cnt) begin
                checks++;
                if (sbq[i].cyc < cnt || dat_oe !== sbq[i].oe ||
                    (sbq[i].oe && dat_out !== sbq[i].d)) begin
                    failures++;
                    $display("FAIL %s cyc=%0d actual oe=%b d=%h expected oe=%b d=%h",
                             sbq[i].req, cnt, dat_oe, dat_out, sbq[i].oe, sbq[i].d);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drv(logic c, logic o, logic w, logic [AW-1:0] a, logic [7:0] d);
        ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
    endtask

    task automatic expect_at(int lag, bit oe, logic [7:0] d, string req);
        exp_t e;
        e.cyc = cnt + lag; e.oe = oe; e.d = d; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic idle();
        drv(1, 1, 1, addr, din);
    endtask

    task automatic write_w(logic [AW-1:0] a, logic [7:0] d);
        drv(0, 1, 1, a, 8'h00); step(1);
        drv(0, 1, 0, a, d);     step(2);
        drv(0, 1, 1, a, d);     step(1);
        idle();                 step(3);
        ref_mem[int'(a)] = d;
    endtask

    task automatic write_e(logic [AW-1:0] a, logic [7:0] d);
        drv(1, 1, 0, a, 8'h00); step(1);
        drv(0, 1, 0, a, d);     step(2);
        drv(1, 1, 0, a, d);     step(1);
        idle();                 step(3);
        ref_mem[int'(a)] = d;
    endtask

    task automatic read(logic [AW-1:0] a, string req);
        drv(0, 0, 1, a, 8'h00);
        expect_at(2, 0, 8'h00, "R2");
        expect_at(3, 1, ref_mem[int'(a)], req);
        step(4);
        idle();
        expect_at(3, 0, 8'h00, req);
        step(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        // R11: reset state
        checks++;
        if (dat_oe !== 1'b0 || dat_out !== 8'h00) begin
            failures++;
            $display("FAIL R11 actual oe=%b d=%h expected oe=0 d=00", dat_oe, dat_out);
        end
        rst_n = 1'b1;
        step(3);

        // R5: write-enable controlled and chip-enable controlled windows, R3 reads
        write_w(11'h005, 8'hA5);
        read(11'h005, "R3");
        write_e(11'h123, 8'h3C);
        read(11'h123, "R5");

        // R1: both ends of the address range
        write_w(11'h7FF, 8'h7E);
        write_e(11'h000, 8'h81);
        read(11'h7FF, "R1");
        read(11'h000, "R1");

        // R4: address change during an active read
        drv(0, 0, 1, 11'h005, 8'h00);
        expect_at(3, 1, 8'hA5, "R4");
        step(2);
        drv(0, 0, 1, 11'h123, 8'h00);
        expect_at(3, 1, 8'h3C, "R4");
        step(4);
        idle(); step(4);

        // R6: data changes inside the window, last value commits
        drv(0, 1, 0, 11'h040, 8'h11); step(2);
        drv(0, 1, 0, 11'h040, 8'h22); step(2);
        drv(0, 1, 1, 11'h040, 8'h22); step(1);
        idle(); step(3);
        ref_mem[32'h040] = 8'h22;
        read(11'h040, "R6");

        // R7 then R9: write enable drops a live read, its rise commits and read sees new byte
        drv(0, 0, 1, 11'h005, 8'h00);
        expect_at(3, 1, 8'hA5, "R7");
        step(4);
        drv(0, 0, 0, 11'h005, 8'h99);
        expect_at(3, 0, 8'h00, "R7");
        step(3);
        drv(0, 0, 1, 11'h005, 8'h99);
        ref_mem[32'h005] = 8'h99;
        expect_at(3, 1, 8'h99, "R9");
        step(4);
        idle(); step(4);

        // R8: simultaneous fall of chip enable and write enable with output enable low
        drv(1, 0, 1, 11'h200, 8'h00); step(1);
        drv(0, 0, 0, 11'h200, 8'h55);
        for (int k = 0; k < 5; k++) begin
            expect_at(3, 0, 8'h00, "R8");
            step(1);
        end
        drv(1, 0, 0, 11'h200, 8'h55);
        expect_at(3, 0, 8'h00, "R8");
        step(1);
        idle(); step(4);
        ref_mem[32'h200] = 8'h55;
        read(11'h200, "R8");

        // R10: protect releases an active read
        drv(0, 0, 1, 11'h123, 8'h00); step(4);
        prot = 1'b1;
        expect_at(1, 0, 8'h00, "R10");
        step(3);
        prot = 1'b0;
        expect_at(1, 1, 8'h3C, "R10");
        step(2);
        idle(); step(4);

        // R10: protect in the middle of a window, no commit, no reopen without a fresh edge
        write_w(11'h300, 8'h0F);
        drv(0, 1, 0, 11'h300, 8'h66); step(3);
        prot = 1'b1; step(1);
        drv(0, 1, 0, 11'h300, 8'h77); step(3);
        prot = 1'b0; step(3);
        drv(0, 1, 1, 11'h300, 8'h77); step(1);
        idle(); step(4);
        read(11'h300, "R10");

        step(6);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule